// File: doc/BRIEF.md
# Timer Update Event Controller

This block is the counting core of a general-purpose timer. A prescaler divides the clock. An up/down counter wraps against an auto-reload limit. Shadow copies of the auto-reload, prescaler and capture/compare values are held inside the block. Software never writes the shadow copies directly. It drives preload values, and these become active only when an update event occurs. An update event is raised by one of three causes:

- a counter wrap (overflow when counting up, underflow when counting down);
- a single-cycle software update strobe;
- an update pulse from an external slave-mode controller.

Request generation is kept separate from event generation. An update-disable control suppresses the event and freezes the shadow copies. Even then, the software strobe and the slave pulse still restart the counter and the prescaler. A request-source control limits the interrupt request, the DMA request and the status flag to counter wraps only.

Whether the counter runs is decided by a two-state machine. In ST_HALT the counter and prescaler hold. In ST_COUNT they advance. There are three transitions:

- HALT to COUNT on a control write with the enable bit set;
- HALT to COUNT on a trigger pulse while trigger-start mode is selected;
- COUNT to HALT on a control write with the enable bit clear.

All control bits are loaded together by one write strobe.

Top module: `tuc_top`

## Requirements
- R1: After reset all control bits are 0, the state is ST_HALT (`cen_o`=0), the counter and prescaler are 0, and `uev_o`, `irq_o`, `dma_o` and `uif_o` are 0. The shadow auto-reload resets to all ones, and the prescaler and compare shadows reset to 0.
- R2: The counter changes only in ST_COUNT or on a restart. The prescaler counts 0 up to its shadow value, and the counter steps once per prescaler wrap, so it steps every (shadow prescaler + 1) clocks.
- R3: Counting up (`ctl_down`=0), the step taken at the active auto-reload value is an overflow and the counter becomes 0. Counting down (`ctl_down`=1), the step taken at 0 is an underflow and the counter becomes the auto-reload value active after that clock.
- R4: With update disable 0, an overflow, underflow, `ug_pulse` or `slv_upd` pulses `uev_o` one clock later. On that same clock edge the auto-reload, prescaler and every compare shadow take their preload values.
- R5: With update disable 1, no cause pulses `uev_o`, and the shadow outputs `arr_o`, `psc_o` and `ccr_o` keep their values.
- R6: `ug_pulse` or `slv_upd` restarts the counter and clears the prescaler whatever the update-disable setting. The counter restarts at 0 when counting up, and at the active auto-reload value when counting down.
- R7: With request source 0, every update event is a request. With request source 1, only events that come from an overflow or underflow are requests.
- R8: A request pulses `irq_o` if `ctl_uie`=1 and `dma_o` if `ctl_ude`=1, one clock later. It sets `uif_o`, which stays set until `uif_clr`. A set in the same clock wins over a clear.
- R9: A `trig_in` pulse moves ST_HALT to ST_COUNT only when trigger-start mode is selected. Otherwise `trig_in` is ignored.
- R10: A control write with `ctl_cen`=0 moves to ST_HALT, and the counter then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Loads all control bits below |
| ctl_cen | input | 1 | Counter enable value |
| ctl_udis | input | 1 | Update disable value |
| ctl_urs | input | 1 | Request source: 1 = wraps only |
| ctl_down | input | 1 | Count direction: 1 = down |
| ctl_trig_mode | input | 1 | Trigger-start mode select |
| ctl_uie | input | 1 | Interrupt request enable |
| ctl_ude | input | 1 | DMA request enable |
| ug_pulse | input | 1 | Software update strobe |
| slv_upd | input | 1 | Slave-mode reset/update pulse |
| trig_in | input | 1 | Trigger start pulse |
| uif_clr | input | 1 | Clears the update status flag |
| arr_pre | input | CNT_W | Auto-reload preload |
| psc_pre | input | PSC_W | Prescaler preload |
| ccr_pre | input | CC_N*CNT_W | Compare preloads, channel 0 in the low bits |
| cnt_o | output | CNT_W | Counter value |
| arr_o | output | CNT_W | Active auto-reload |
| psc_o | output | PSC_W | Active prescaler |
| ccr_o | output | CC_N*CNT_W | Active compare values |
| cen_o | output | 1 | 1 in ST_COUNT |
| uev_o | output | 1 | Update event pulse |
| uif_o | output | 1 | Update status flag |
| irq_o | output | 1 | Interrupt request pulse |
| dma_o | output | 1 | DMA request pulse |

## Verification
The assertions check these properties on every cycle:

- the counter holds when it is neither ticking nor restarted;
- an overflow lands on 0, and an underflow lands on the new auto-reload value;
- the prescaler stays within its limit;
- the shadow registers are frozen while updates are disabled;
- no request is raised for a software or slave cause while the request source is set to wraps only;
- requests never appear without their enable.

The bench's scenarios are needed for the rest:

- the exact timing of wraps under a changing prescaler;
- preload values being taken only at the event;
- the restart of the counter while events are disabled;
- the down-count reload;
- the trigger start, which must work in trigger-start mode and be ignored outside it.

// File: rtl/tuc_pkg.sv
package tuc_pkg;
    typedef enum logic [0:0] {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tuc_state_e;
endpackage

// File: rtl/tuc_run_fsm.sv
module tuc_run_fsm
    import tuc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic sw_cen,
    input  logic trig_mode,
    input  logic trig_in,
    output logic run
);
    tuc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if ((sw_we && sw_cen) || (trig_mode && trig_in))
                    state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (sw_we && !sw_cen && !(trig_mode && trig_in))
                    state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb run = (state_q == ST_COUNT);

    // R9: trigger ignored outside trigger-start mode
    a_r9_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !sw_we && !trig_mode) |=> (state_q == ST_HALT));
endmodule

// File: rtl/tuc_prescaler.sv
module tuc_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] lim,
    output logic             tick
);
    localparam logic [PSC_W-1:0] ONE = PSC_W'(1);
    logic [PSC_W-1:0] pc_q;

    always_comb tick = run && (pc_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc_q <= '0;
        else if (clr)      pc_q <= '0;
        else if (tick)     pc_q <= '0;
        else if (run)      pc_q <= pc_q + ONE;
    end

    // R2: prescaler never exceeds its active limit
    a_r2_psc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= lim);
endmodule

// File: rtl/tuc_counter.sv
module tuc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             down,
    input  logic             reinit,
    input  logic [CNT_W-1:0] arr_cur,
    input  logic [CNT_W-1:0] arr_next,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             unf
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        ovf = tick && !down && (cnt_q == arr_cur);
        unf = tick &&  down && (cnt_q == '0);
        cnt = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (reinit)    cnt_q <= down ? arr_next : '0;
        else if (ovf)       cnt_q <= '0;
        else if (unf)       cnt_q <= arr_next;
        else if (tick)      cnt_q <= down ? cnt_q - ONE : cnt_q + ONE;
    end

    // R2: counter holds without a tick or a restart
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reinit) |=> $stable(cnt_q));
    // R3: overflow lands on zero
    a_r3_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reinit) |=> (cnt_q == '0));
    // R3: underflow lands on the new reload value
    a_r3_unf_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !reinit) |=> (cnt_q == $past(arr_next)));
endmodule

// File: rtl/tuc_shadow.sv
module tuc_shadow #(
    parameter int          W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] pre,
    output logic [W-1:0] act
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     act <= RST;
        else if (load)  act <= pre;
    end
endmodule

// File: rtl/tuc_top.sv
module tuc_top #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int CC_N  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_we,
    input  logic                  ctl_cen,
    input  logic                  ctl_udis,
    input  logic                  ctl_urs,
    input  logic                  ctl_down,
    input  logic                  ctl_trig_mode,
    input  logic                  ctl_uie,
    input  logic                  ctl_ude,
    input  logic                  ug_pulse,
    input  logic                  slv_upd,
    input  logic                  trig_in,
    input  logic                  uif_clr,
    input  logic [CNT_W-1:0]      arr_pre,
    input  logic [PSC_W-1:0]      psc_pre,
    input  logic [CC_N*CNT_W-1:0] ccr_pre,
    output logic [CNT_W-1:0]      cnt_o,
    output logic [CNT_W-1:0]      arr_o,
    output logic [PSC_W-1:0]      psc_o,
    output logic [CC_N*CNT_W-1:0] ccr_o,
    output logic                  cen_o,
    output logic                  uev_o,
    output logic                  uif_o,
    output logic                  irq_o,
    output logic                  dma_o
);
    localparam logic [CNT_W-1:0] ARR_RST = '1;

    logic udis_q, urs_q, down_q, tmode_q, uie_q, ude_q;
    logic run, tick, ovf, unf, restart, wrap, uev, req;
    logic [CNT_W-1:0] arr_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            udis_q  <= 1'b0;
            urs_q   <= 1'b0;
            down_q  <= 1'b0;
            tmode_q <= 1'b0;
            uie_q   <= 1'b0;
            ude_q   <= 1'b0;
        end else if (ctl_we) begin
            udis_q  <= ctl_udis;
            urs_q   <= ctl_urs;
            down_q  <= ctl_down;
            tmode_q <= ctl_trig_mode;
            uie_q   <= ctl_uie;
            ude_q   <= ctl_ude;
        end
    end

    tuc_run_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .sw_we(ctl_we), .sw_cen(ctl_cen),
        .trig_mode(tmode_q), .trig_in(trig_in), .run(run)
    );

    always_comb begin
        restart  = ug_pulse || slv_upd;
        wrap     = ovf || unf;
        uev      = !udis_q && (wrap || restart);
        req      = uev && (!urs_q || wrap);
        arr_next = uev ? arr_pre : arr_o;
    end

    tuc_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(restart),
        .lim(psc_o), .tick(tick)
    );

    tuc_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .down(down_q),
        .reinit(restart), .arr_cur(arr_o), .arr_next(arr_next),
        .cnt(cnt_o), .ovf(ovf), .unf(unf)
    );

    tuc_shadow #(.W(CNT_W), .RST(ARR_RST)) i_arr_sh (
        .clk(clk), .rst_n(rst_n), .load(uev), .pre(arr_pre), .act(arr_o)
    );
    tuc_shadow #(.W(PSC_W), .RST('0)) i_psc_sh (
        .clk(clk), .rst_n(rst_n), .load(uev), .pre(psc_pre), .act(psc_o)
    );

    for (genvar g = 0; g < CC_N; g++) begin : g_ccr
        tuc_shadow #(.W(CNT_W), .RST('0)) i_ccr_sh (
            .clk(clk), .rst_n(rst_n), .load(uev),
            .pre(ccr_pre[g*CNT_W +: CNT_W]), .act(ccr_o[g*CNT_W +: CNT_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uev_o <= 1'b0;
            irq_o <= 1'b0;
            dma_o <= 1'b0;
            uif_o <= 1'b0;
        end else begin
            uev_o <= uev;
            irq_o <= req && uie_q;
            dma_o <= req && ude_q;
            if (req)          uif_o <= 1'b1;
            else if (uif_clr) uif_o <= 1'b0;
        end
    end

    always_comb cen_o = run;

    // R5: shadows frozen while updates are disabled
    a_r5_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        udis_q |=> ($stable(arr_o) && $stable(psc_o) && $stable(ccr_o)));
    // R5: no event while updates are disabled
    a_r5_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        udis_q |=> !uev_o);
    // R7: wraps-only source blocks software and slave requests
    a_r7_urs_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (urs_q && !ovf && !unf) |=> (!irq_o && !dma_o));
    // R8: requests need their enables
    a_r8_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !uie_q |=> !irq_o);
    a_r8_dma_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ude_q |=> !dma_o);
endmodule

// File: tb/test_tuc_top.sv
module test_tuc_top;
    localparam int CNT_W = 8;
    localparam int PSC_W = 4;
    localparam int CC_N  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_cen = 0, ctl_udis = 0, ctl_urs = 0, ctl_down = 0;
    logic ctl_trig_mode = 0, ctl_uie = 0, ctl_ude = 0;
    logic ug_pulse = 0, slv_upd = 0, trig_in = 0, uif_clr = 0;
    logic [CNT_W-1:0] arr_pre = '0;
    logic [PSC_W-1:0] psc_pre = '0;
    logic [CC_N*CNT_W-1:0] ccr_pre = '0;
    logic [CNT_W-1:0] cnt_o, arr_o;
    logic [PSC_W-1:0] psc_o;
    logic [CC_N*CNT_W-1:0] ccr_o;
    logic cen_o, uev_o, uif_o, irq_o, dma_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // behavioural reference state
    int m_cen = 0, m_udis = 0, m_urs = 0, m_down = 0, m_tm = 0, m_uie = 0, m_ude = 0;
    int m_cnt = 0, m_pc = 0, m_arr = (1 << CNT_W) - 1, m_psc = 0;
    int m_ccr [CC_N];
    int m_uev = 0, m_irq = 0, m_dma = 0, m_uif = 0;

    always #2 clk = ~clk;

    tuc_top #(.CNT_W(CNT_W), .PSC_W(PSC_W), .CC_N(CC_N)) i_tuc_top (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int tick, ovf, unf, sw, uev, req, arrn;
        tick = (m_cen != 0) && (m_pc == m_psc);
        ovf  = tick && !m_down && (m_cnt == m_arr);
        unf  = tick &&  m_down && (m_cnt == 0);
        sw   = ug_pulse || slv_upd;
        uev  = !m_udis && (ovf || unf || sw);
        req  = uev && (!m_urs || ovf || unf);
        arrn = uev ? int'(arr_pre) : m_arr;
        if (sw) begin
            m_cnt = m_down ? arrn : 0;
            m_pc  = 0;
        end else if (tick) begin
            m_pc = 0;
            if (ovf)       m_cnt = 0;
            else if (unf)  m_cnt = arrn;
            else           m_cnt = m_down ? m_cnt - 1 : m_cnt + 1;
        end else if (m_cen != 0) begin
            m_pc = m_pc + 1;
        end
        if (uev) begin
            m_arr = int'(arr_pre);
            m_psc = int'(psc_pre);
            for (int c = 0; c < CC_N; c++) m_ccr[c] = int'(ccr_pre[c*CNT_W +: CNT_W]);
        end
        m_uev = uev;
        m_irq = req && m_uie;
        m_dma = req && m_ude;
        if (req) m_uif = 1;
        else if (uif_clr) m_uif = 0;
        if (ctl_we) m_cen = ctl_cen;
        if (m_tm && trig_in) m_cen = 1;
        if (ctl_we) begin
            m_udis = ctl_udis; m_urs = ctl_urs; m_down = ctl_down;
            m_tm = ctl_trig_mode; m_uie = ctl_uie; m_ude = ctl_ude;
        end
    endtask

    task automatic compare();
        chk("R3", "cnt", int'(cnt_o), m_cnt);
        chk("R4", "uev", int'(uev_o), m_uev);
        chk("R5", "arr", int'(arr_o), m_arr);
        chk("R5", "psc", int'(psc_o), m_psc);
        for (int c = 0; c < CC_N; c++)
            chk("R4", "ccr", int'(ccr_o[c*CNT_W +: CNT_W]), m_ccr[c]);
        chk("R7", "irq", int'(irq_o), m_irq);
        chk("R8", "dma", int'(dma_o), m_dma);
        chk("R8", "uif", int'(uif_o), m_uif);
        chk("R9", "cen", int'(cen_o), m_cen);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_ctl(input logic cen, udis, urs, down, tm, uie, ude);
        ctl_cen = cen; ctl_udis = udis; ctl_urs = urs; ctl_down = down;
        ctl_trig_mode = tm; ctl_uie = uie; ctl_ude = ude; ctl_we = 1;
        cyc();
        ctl_we = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < CC_N; c++) m_ccr[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "cnt reset", int'(cnt_o), 0);
        chk("R1", "cen reset", int'(cen_o), 0);
        chk("R1", "irq reset", int'(irq_o), 0);
        chk("R1", "uif reset", int'(uif_o), 0);
        chk("R1", "arr reset", int'(arr_o), (1 << CNT_W) - 1);

        arr_pre = 8'd4; psc_pre = 4'd0; ccr_pre = 16'h2211;
        wr_ctl(0, 0, 0, 0, 0, 1, 0);
        ug_pulse = 1; cyc(); ug_pulse = 0;
        chk("R4", "uev after strobe", int'(uev_o), 1);
        chk("R4", "arr loaded", int'(arr_o), 4);
        chk("R7", "irq on strobe", int'(irq_o), 1);
        run_n(3);
        chk("R2", "stopped counter holds", int'(cnt_o), 0);

        wr_ctl(1, 0, 0, 0, 0, 1, 0);
        run_n(12);
        uif_clr = 1; cyc(); uif_clr = 0;
        psc_pre = 4'd2; arr_pre = 8'd3;
        run_n(24);

        // R7: wraps-only source
        wr_ctl(1, 0, 1, 0, 0, 1, 1);
        uif_clr = 1; cyc(); uif_clr = 0;
        ug_pulse = 1; cyc(); ug_pulse = 0;
        chk("R7", "no irq for strobe", int'(irq_o), 0);
        chk("R4", "event for strobe", int'(uev_o), 1);
        run_n(16);

        // R5/R6: updates disabled
        wr_ctl(1, 1, 1, 0, 0, 1, 1);
        arr_pre = 8'd7; psc_pre = 4'd0;
        run_n(15);
        chk("R5", "arr frozen", int'(arr_o), 3);
        ug_pulse = 1; cyc(); ug_pulse = 0;
        chk("R6", "restart while disabled", int'(cnt_o), 0);
        chk("R5", "no event while disabled", int'(uev_o), 0);
        run_n(6);

        // down counting via slave update
        wr_ctl(1, 0, 0, 1, 0, 1, 1);
        slv_upd = 1; cyc(); slv_upd = 0;
        chk("R6", "down restart at reload", int'(cnt_o), 7);
        run_n(20);

        // R10: software disable
        wr_ctl(0, 0, 0, 1, 0, 1, 1);
        run_n(5);
        chk("R10", "halted", int'(cen_o), 0);

        // R9: trigger
        trig_in = 1; cyc(); trig_in = 0;
        chk("R9", "trigger ignored", int'(cen_o), 0);
        wr_ctl(0, 0, 0, 0, 1, 1, 0);
        trig_in = 1; cyc(); trig_in = 0;
        chk("R9", "trigger starts", int'(cen_o), 1);
        run_n(10);
        finish_run();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
                finish_run();
            end
        end
    end
endmodule